// File: doc/BRIEF.md
# Frame-Synchronised Serial Transmit Port

This block serialises a parallel word onto a single data line under the control of an external bit clock and a frame-sync strobe. Software places a word in a holding register. While the port waits, it already drives the most significant bit of that pending word onto the line. When frame sync is seen active on the sampling edge of the bit clock, the word moves into the shift register. The remaining bits then leave MSB first, one per launching edge. The word length can be 8, 10, 12 or 16 bits. A word of length L occupies bits L-1..0 of the written value.

Both the bit clock and frame sync arrive as raw levels. They are brought into the system clock domain through a synchroniser chain and turned into launch and sample events. Two polarity controls swap the roles of the clock edges and the active level of frame sync. A PCM-style option drives the data line only during a word's slot and releases it otherwise. The output enable is given as a separate pin for the pad. Two flags report the port's state. One shows that the holding register has been consumed. The other shows that a frame started with no fresh word, in which case the previous word was repeated.

Top module: `sertx_port`

## Requirements
- R1: While `rst` is high and after it, `tx_empty` is 1, `underrun` is 0, `dout` is 0 and `dout_oe` equals the inverse of `pcm_mode`.
- R2: A write pulse (`wr_en`) clears `tx_empty`. The move of the holding word into the shift register, on frame detection, sets `tx_empty` again.
- R3: `wlen_sel` picks the word length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. Bits leave MSB first, bit L-1 down to bit 0. The line changes once per launching edge.
- R4: When no word is in flight, `dout` carries bit L-1 of the holding word. It stays there through the frame-sync sampling edge until the first launching edge that follows it.
- R5: With `clk_pol` at 0, a rising bit-clock edge launches data and a falling edge samples frame sync. With `clk_pol` at 1 the roles swap. `dout` never changes on a sampling edge.
- R6: With `fs_pol` at 0, frame sync is active high. With `fs_pol` at 1 it is active low.
- R7: When `pcm_mode` is 1, `dout_oe` is 0 while idle. It rises on the first launching edge after frame detection and falls on the launching edge that ends the word. When `pcm_mode` is 0, `dout_oe` is always 1.
- R8: If frame sync is detected while `tx_empty` is 1, the last holding word is sent again and `underrun` becomes 1. A write clears `underrun`.
- R9: Frame sync that is active on a sampling edge while a word is in flight has no effect. The word completes unchanged and no new word starts.
- R10: When the bit clock stops at any point, `dout`, `dout_oe` and the flags hold their values indefinitely. The word resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Raw bit clock level |
| fsync_in | input | 1 | Raw frame-sync level |
| clk_pol | input | 1 | Bit-clock edge role select |
| fs_pol | input | 1 | Frame-sync active level select |
| pcm_mode | input | 1 | Release data line outside word slots |
| wlen_sel | input | 2 | Word length code (8/10/12/16) |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 16 | Word to transmit, right-aligned |
| dout | output | 1 | Serial data |
| dout_oe | output | 1 | Data line drive enable |
| tx_empty | output | 1 | Holding register consumed |
| underrun | output | 1 | Frame sent with no fresh word |

## Verification
A wrong bit count or a wrong shift direction shows on `dout` at the next launching edge. A stuck or mis-sequenced state shows within one bit-clock period, as the predriven MSB failing to hold or `dout_oe` moving on the wrong edge in PCM mode. Flag errors show at the port one system clock after the write or frame detection that should change them. The bench sweeps every combination of word length, both polarities and PCM mode. Each configuration runs a full frame, checked bit by bit. Some configurations add a repeated frame without a write, a frame-sync pulse in the middle of a word, or a long clock stall.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int WORD_MAX = 16;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic launch;
        logic sample;
        logic fs_act;
    } bitclk_ev_t;

    function automatic logic [CNT_W-1:0] word_len(input logic [1:0] sel);
        case (sel)
            2'd0:    word_len = CNT_W'(8);
            2'd1:    word_len = CNT_W'(10);
            2'd2:    word_len = CNT_W'(12);
            default: word_len = CNT_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/sertx_edge.sv
module sertx_edge
    import sertx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_raw,
    input  logic       fs_raw,
    input  logic       clk_pol,
    input  logic       fs_pol,
    output bitclk_ev_t ev
);

    logic [1:0] chain [STAGES];
    logic       eff_clk;
    logic       prev_clk;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 2'b00;
                    else     chain[0] <= {fs_raw, sclk_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 2'b00;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign eff_clk = chain[STAGES-1][0] ^ clk_pol;

    always_ff @(posedge clk) begin
        if (rst) prev_clk <= 1'b0;
        else     prev_clk <= eff_clk;
    end

    always_comb begin
        ev.launch = eff_clk & ~prev_clk;
        ev.sample = ~eff_clk & prev_clk;
        ev.fs_act = chain[STAGES-1][1] ^ fs_pol;
    end

    // a second launch needs a sample edge in between
    assert_launch_alternates_R5: assert property (@(posedge clk) disable iff (rst)
        ev.launch |=> !ev.launch);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_MAX-1:0] wr_data,
    input  logic                load,
    output logic [WORD_MAX-1:0] word_o,
    output logic                empty_o,
    output logic                underrun_o
);

    logic full_q;
    logic urun_q;
    logic [WORD_MAX-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            full_q <= 1'b0;
            urun_q <= 1'b0;
        end else if (wr_en) begin
            word_q <= wr_data;
            full_q <= 1'b1;
            urun_q <= 1'b0;
        end else if (load) begin
            full_q <= 1'b0;
            urun_q <= urun_q | ~full_q;
        end
    end

    assign word_o     = word_q;
    assign empty_o    = ~full_q;
    assign underrun_o = urun_q;

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !empty_o);

    assert_load_empties_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> empty_o);

    assert_underrun_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !underrun_o);

    assert_underrun_on_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en && empty_o) |=> underrun_o);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bitclk_ev_t          ev,
    input  logic [1:0]          wlen_sel,
    input  logic                pcm_mode,
    input  logic [WORD_MAX-1:0] hold_word,
    output logic                load,
    output logic                busy,
    output logic                dout,
    output logic                dout_oe
);

    tx_state_e           st_q;
    logic [WORD_MAX-1:0] sr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    len;
    logic [3:0]          msb_idx;

    assign len     = word_len(wlen_sel);
    assign msb_idx = 4'(len - CNT_W'(1));
    assign load    = (st_q == ST_IDLE) && ev.sample && ev.fs_act;
    assign busy    = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (load) begin
                        sr_q <= hold_word;
                        st_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (ev.launch) begin
                        cnt_q <= CNT_W'(1);
                        st_q  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (ev.launch) begin
                        if (cnt_q == len) begin
                            st_q <= ST_IDLE;
                        end else begin
                            sr_q  <= {sr_q[WORD_MAX-2:0], 1'b0};
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (st_q == ST_IDLE) dout = hold_word[msb_idx];
        else                 dout = sr_q[msb_idx];
        dout_oe = pcm_mode ? (st_q == ST_SEND) : 1'b1;
    end

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEND) |-> (cnt_q >= CNT_W'(1) && cnt_q <= len));

    assert_static_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!ev.launch && !ev.sample) |=> $stable(st_q) && $stable(sr_q));

    assert_no_shift_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && !ev.launch) |=> $stable(sr_q));

endmodule

// File: rtl/sertx_port.sv
module sertx_port
    import sertx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk_in,
    input  logic        fsync_in,
    input  logic        clk_pol,
    input  logic        fs_pol,
    input  logic        pcm_mode,
    input  logic [1:0]  wlen_sel,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        dout,
    output logic        dout_oe,
    output logic        tx_empty,
    output logic        underrun
);

    bitclk_ev_t          ev;
    logic                load;
    logic                busy;
    logic [WORD_MAX-1:0] hold_word;

    sertx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .sclk_raw (sclk_in),
        .fs_raw   (fsync_in),
        .clk_pol  (clk_pol),
        .fs_pol   (fs_pol),
        .ev       (ev)
    );

    sertx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .load       (load),
        .word_o     (hold_word),
        .empty_o    (tx_empty),
        .underrun_o (underrun)
    );

    sertx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .wlen_sel  (wlen_sel),
        .pcm_mode  (pcm_mode),
        .hold_word (hold_word),
        .load      (load),
        .busy      (busy),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assert_pcm_release_R7: assert property (@(posedge clk) disable iff (rst)
        (pcm_mode && !busy) |-> !dout_oe);

    assert_plain_drive_R7: assert property (@(posedge clk) disable iff (rst)
        !pcm_mode |-> dout_oe);

    assert_midword_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en && !tx_empty) |=> !tx_empty);

endmodule

// File: tb/sertx_port_test.sv
module sertx_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_in = 1'b0;
    logic        fsync_in = 1'b0;
    logic        clk_pol = 1'b0;
    logic        fs_pol = 1'b0;
    logic        pcm_mode = 1'b0;
    logic [1:0]  wlen_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        dout;
    logic        dout_oe;
    logic        tx_empty;
    logic        underrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sertx_port uut (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .fsync_in(fsync_in),
        .clk_pol(clk_pol), .fs_pol(fs_pol), .pcm_mode(pcm_mode),
        .wlen_sel(wlen_sel), .wr_en(wr_en), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .tx_empty(tx_empty), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic half(input bit lvl);
        sclk_in = lvl ^ clk_pol;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int len, input bit mid_fs, input bit stall);
        // R4: MSB predriven while idle
        chk(dout == w[len-1], "R4 predrive", int'(dout), int'(w[len-1]));
        chk(dout_oe == !pcm_mode, "R7 idle oe", int'(dout_oe), int'(!pcm_mode));
        fsync_in = ~fs_pol;             // R6: active level
        half(1'b0);                     // sampling edge
        chk(dout == w[len-1], "R4 held past sample", int'(dout), int'(w[len-1]));
        chk(dout_oe == !pcm_mode, "R7 oe before first launch", int'(dout_oe), int'(!pcm_mode));
        chk(tx_empty == 1'b1, "R2 empty after load", int'(tx_empty), 1);
        for (int i = 0; i < len; i++) begin
            fsync_in = fs_pol;
            half(1'b1);
            chk(dout == w[len-1-i], "R3 bit order", int'(dout), int'(w[len-1-i]));
            chk(dout_oe == 1'b1, "R7 oe in slot", int'(dout_oe), 1);
            if (mid_fs && i == len / 2) fsync_in = ~fs_pol;   // R9
            half(1'b0);
            chk(dout == w[len-1-i], "R5 stable on sample", int'(dout), int'(w[len-1-i]));
            if (stall && i == 2) begin
                repeat (200) @(negedge clk);
                chk(dout == w[len-1-i], "R10 stall data", int'(dout), int'(w[len-1-i]));
                chk(dout_oe == 1'b1, "R10 stall oe", int'(dout_oe), 1);
            end
        end
        fsync_in = fs_pol;
        half(1'b1);
        chk(dout_oe == !pcm_mode, "R7 oe after word", int'(dout_oe), int'(!pcm_mode));
    endtask

    initial begin
        @(negedge clk);
        for (int cfg = 0; cfg < 32; cfg++) begin
            automatic int len;
            automatic logic [15:0] w;
            automatic logic [15:0] w2;
            wlen_sel = cfg[1:0];
            clk_pol  = cfg[2];
            fs_pol   = cfg[3];
            pcm_mode = cfg[4];
            len = (cfg[1:0] == 2'd0) ? 8 : (cfg[1:0] == 2'd1) ? 10 : (cfg[1:0] == 2'd2) ? 12 : 16;
            rst = 1'b1;
            fsync_in = fs_pol;
            sclk_in = ~clk_pol;
            repeat (4) @(negedge clk);
            chk(tx_empty == 1'b1 && underrun == 1'b0, "R1 reset flags",
                int'({tx_empty, underrun}), 2);
            chk(dout == 1'b0, "R1 reset dout", int'(dout), 0);
            chk(dout_oe == !pcm_mode, "R1 reset oe", int'(dout_oe), int'(!pcm_mode));
            rst = 1'b0;
            repeat (4) @(negedge clk);
            w = 16'((cfg * 16'h3A5D + 16'h1C39) & ((1 << len) - 1));
            wr(w);
            chk(tx_empty == 1'b0, "R2 write clears empty", int'(tx_empty), 0);
            frame(w, len, (cfg % 4) == 2, (cfg % 4) == 3);
            chk(tx_empty == 1'b1, "R2 empty after frame", int'(tx_empty), 1);
            chk(underrun == 1'b0, "R8 no underrun", int'(underrun), 0);
            if ((cfg % 4) == 2) begin
                // R9: the mid-word pulse must not have begun another word
                half(1'b0);
                half(1'b1);
                chk(dout_oe == !pcm_mode, "R9 no restart oe", int'(dout_oe), int'(!pcm_mode));
                chk(dout == w[len-1], "R9 idle predrive", int'(dout), int'(w[len-1]));
            end
            if ((cfg % 4) == 1) begin
                frame(w, len, 1'b0, 1'b0);   // R8: repeat of last word
                chk(underrun == 1'b1, "R8 underrun set", int'(underrun), 1);
                w2 = ~w & 16'((1 << len) - 1);
                wr(w2);
                chk(underrun == 1'b0, "R8 write clears underrun", int'(underrun), 0);
                frame(w2, len, 1'b0, 1'b0);
                chk(underrun == 1'b0, "R8 fresh word no underrun", int'(underrun), 0);
            end
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule